// File: doc/BRIEF.md
# Calendar Clock Setting Controller

This block keeps a simplified calendar clock that advances on a one-second tick. The clock holds seconds, minutes, hours, day, month and a two-digit year. Every month has 30 days and there are no leap years. The block also holds an alarm time. Four single-cycle key pulses drive it: page/next (mode), adjust, up and down. From these it selects which three two-digit values go to the display and which digit pair should blink while a field is being edited.

Time is set from a menu. Adjust on the time page opens setting mode with the minutes selected. The mode key then steps through the editable fields, and up/down change the selected field. A second adjust, or twenty idle seconds, returns to the time page. The alarm page has its own menu for the alarm minute and alarm hour. An alarm hour of 24 means the alarm is off. The digit decoder, display scanner, key debouncer and alarm comparator sit outside this block and take its outputs.

Top module: `cal_clock_ctrl`

## Requirements
- R1: After reset the time page is shown. The time reads 00:00:00, the date reads year 0, month 1, day 1, the alarm is 24:00 (off), and the blink select is 000.
- R2: Outside setting mode, each mode pulse moves the page from time to date, then to alarm, then back to time. The time page shows hours on the left, minutes in the middle and seconds on the right. The date page shows year, month, day. The alarm page shows alarm hour, alarm minute, 0.
- R3: Adjust on the time page enters setting mode with minutes selected. Adjust on the date page has no effect.
- R4: In setting mode, mode pulses select fields in the cyclic order minutes, hours, day, month, year, then minutes again. Each field has a blink code and a page: minutes 010 (time page), hours 100 (time page), day 001 (date page), month 010 (date page), year 100 (date page). Blink is one-hot and is 000 outside any setting mode.
- R5: Up adds one to the selected field and down subtracts one, effective on the next cycle. Seconds are never editable. An edit in the same cycle as a tick wins for the edited field.
- R6: Edits saturate instead of wrapping. The limits are minutes 0..59, hours 0..23, day 1..30, month 1..12, year 0..99, alarm minute 0..59 and alarm hour 0..24.
- R7: Adjust in setting mode leaves it, shows the time page with blink 000 and keeps all edits.
- R8: Setting mode is left for the time page on the 20th tick with no key pulse. Any key pulse restarts that count.
- R9: Time keeps counting in every mode. A tick at day 30 23:59:59 gives day 1 00:00:00 of the next month. Month 12 rolls to month 1 and increments the year, and year 99 wraps to 0.
- R10: Adjust on the alarm page enters alarm editing with the minute selected (blink 010). Mode toggles between minute and hour (blink 100). Adjust returns to the alarm page. The alarm hour and minute are also output directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| key_mode_i | input | 1 | Page / next-field key pulse |
| key_adj_i | input | 1 | Adjust key pulse (enter / confirm) |
| key_up_i | input | 1 | Increment key pulse |
| key_dn_i | input | 1 | Decrement key pulse |
| disp_left_o | output | 7 | Binary value for the left digit pair |
| disp_mid_o | output | 7 | Binary value for the middle digit pair |
| disp_right_o | output | 7 | Binary value for the right digit pair |
| blink_sel_o | output | 3 | One-hot blink pair: 100 left, 010 middle, 001 right |
| alarm_hr_o | output | 7 | Alarm hour, 24 = off |
| alarm_min_o | output | 7 | Alarm minute |

## Verification
The page sequence is tried from the time, date and alarm pages. An adjust pulse on the date page is used to separate a page-aware key decoder from one that reacts everywhere. The edit keys are pushed well past each field's limit, which tells saturating editors apart from wrapping ones. The field cycle is walked fully around to confirm both its order and the blink code and page of each field. Ticks are given during setting mode to show that timekeeping continues. The idle timeout is tried with a key pulse at tick 19, which tells an idle count that restarts from one that measures time since entry. A single tick at day 30, month 12, year 99, 23:59:59 exercises every carry in the chain at once.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int VAL_W = 7;
   typedef logic [VAL_W-1:0] val_t;

   typedef enum logic [3:0] {
      ST_TIME  = 4'd0,
      ST_DATE  = 4'd1,
      ST_ALARM = 4'd2,
      ST_SMIN  = 4'd3,
      ST_SHR   = 4'd4,
      ST_SDAY  = 4'd5,
      ST_SMON  = 4'd6,
      ST_SYR   = 4'd7,
      ST_AMIN  = 4'd8,
      ST_AHR   = 4'd9
   } menu_st_e;

   typedef enum logic [2:0] {
      FLD_NONE = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HR   = 3'd2,
      FLD_DAY  = 3'd3,
      FLD_MON  = 3'd4,
      FLD_YR   = 3'd5,
      FLD_AMIN = 3'd6,
      FLD_AHR  = 3'd7
   } fld_e;

   localparam logic [2:0] BLK_NONE  = 3'b000;
   localparam logic [2:0] BLK_LEFT  = 3'b100;
   localparam logic [2:0] BLK_MID   = 3'b010;
   localparam logic [2:0] BLK_RIGHT = 3'b001;

   function automatic val_t sat_step(input val_t cur, input logic inc,
                                     input logic dec, input val_t lo, input val_t hi);
      if (inc)      return (cur >= hi) ? cur : cur + 1'b1;
      else if (dec) return (cur <= lo) ? cur : cur - 1'b1;
      else          return cur;
   endfunction

   function automatic logic is_setting(input menu_st_e s);
      case (s)
         ST_SMIN, ST_SHR, ST_SDAY, ST_SMON, ST_SYR, ST_AMIN, ST_AHR: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic fld_e state_field(input menu_st_e s);
      case (s)
         ST_SMIN: return FLD_MIN;
         ST_SHR:  return FLD_HR;
         ST_SDAY: return FLD_DAY;
         ST_SMON: return FLD_MON;
         ST_SYR:  return FLD_YR;
         ST_AMIN: return FLD_AMIN;
         ST_AHR:  return FLD_AHR;
         default: return FLD_NONE;
      endcase
   endfunction

   // position of a calendar field in the carry chain; 7 = not in the chain
   function automatic logic [2:0] chain_idx(input fld_e f);
      case (f)
         FLD_MIN: return 3'd1;
         FLD_HR:  return 3'd2;
         FLD_DAY: return 3'd3;
         FLD_MON: return 3'd4;
         FLD_YR:  return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/cal_timekeep.sv
module cal_timekeep
   import cal_pkg::*;
#(
   parameter int SEC_PER_MIN = 60,
   parameter int MIN_PER_HR  = 60,
   parameter int HR_PER_DAY  = 24,
   parameter int DAY_PER_MON = 30,
   parameter int MON_PER_YR  = 12,
   parameter int YR_SPAN     = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic ed_inc,
   input  logic ed_dec,
   input  fld_e ed_fld,
   output val_t sec_o,
   output val_t min_o,
   output val_t hr_o,
   output val_t day_o,
   output val_t mon_o,
   output val_t yr_o
);

   localparam int NF = 6;
   localparam val_t LO [NF] = '{val_t'(0), val_t'(0), val_t'(0),
                                val_t'(1), val_t'(1), val_t'(0)};
   localparam val_t HI [NF] = '{val_t'(SEC_PER_MIN-1), val_t'(MIN_PER_HR-1),
                                val_t'(HR_PER_DAY-1),  val_t'(DAY_PER_MON),
                                val_t'(MON_PER_YR),    val_t'(YR_SPAN-1)};

   initial begin : elab_chk
      AST_PARAM_FIT: assert (YR_SPAN <= 2**VAL_W && SEC_PER_MIN <= 2**VAL_W &&
                             MIN_PER_HR <= 2**VAL_W && DAY_PER_MON < 2**VAL_W &&
                             MON_PER_YR < 2**VAL_W && HR_PER_DAY < 2**VAL_W)
         else $error("field limit exceeds value width"); // R6
      AST_PARAM_MIN: assert (SEC_PER_MIN > 1 && MIN_PER_HR > 1 && HR_PER_DAY > 1 &&
                             DAY_PER_MON > 1 && MON_PER_YR > 1 && YR_SPAN > 1)
         else $error("field span too small"); // R9
   end

   logic [NF-1:0] carry;
   val_t          cur [NF];
   logic [2:0]    ed_pos;

   assign carry[0] = tick;
   assign ed_pos   = chain_idx(ed_fld);

   generate
      for (genvar gi = 0; gi < NF; gi++) begin : g_fld
         val_t q;
         val_t nxt;
         logic sel;

         assign sel     = (ed_inc | ed_dec) && (ed_pos == 3'(gi));
         assign cur[gi] = q;

         if (gi < NF-1) begin : g_carry
            assign carry[gi+1] = carry[gi] && (q == HI[gi]);
         end

         always_comb begin
            nxt = q;
            if (carry[gi]) nxt = (q == HI[gi]) ? LO[gi] : q + 1'b1;
            if (sel)       nxt = sat_step(q, ed_inc, ed_dec, LO[gi], HI[gi]);
         end

         always_ff @(posedge clk) begin
            if (rst) q <= LO[gi];
            else     q <= nxt;
         end
      end
   endgenerate

   assign sec_o = cur[0];
   assign min_o = cur[1];
   assign hr_o  = cur[2];
   assign day_o = cur[3];
   assign mon_o = cur[4];
   assign yr_o  = cur[5];

   AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
      sec_o <= HI[0]); // R9
   AST_DAY_RANGE: assert property (@(posedge clk) disable iff (rst)
      day_o >= LO[3] && day_o <= HI[3]); // R9
   AST_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
      (tick && !ed_inc && !ed_dec && sec_o == HI[0] && min_o == HI[1] &&
       hr_o == HI[2] && day_o == HI[3]) |=> (day_o == LO[3] && hr_o == LO[2])); // R9
   AST_MIN_SAT: assert property (@(posedge clk) disable iff (rst)
      (ed_inc && ed_fld == FLD_MIN && min_o == HI[1]) |=> min_o == HI[1]); // R6
   AST_SEC_NO_EDIT: assert property (@(posedge clk) disable iff (rst)
      ((ed_inc || ed_dec) && !tick) |=> $stable(sec_o)); // R5

endmodule

// File: rtl/cal_alarm_set.sv
module cal_alarm_set
   import cal_pkg::*;
#(
   parameter int MIN_PER_HR = 60,
   parameter int HR_PER_DAY = 24
) (
   input  logic clk,
   input  logic rst,
   input  logic ed_inc,
   input  logic ed_dec,
   input  fld_e ed_fld,
   output val_t ahr_o,
   output val_t amin_o
);

   localparam val_t AHR_OFF = val_t'(HR_PER_DAY);
   localparam val_t AMIN_HI = val_t'(MIN_PER_HR-1);

   initial begin : elab_chk
      AST_ALM_FIT: assert (HR_PER_DAY < 2**VAL_W && MIN_PER_HR <= 2**VAL_W)
         else $error("alarm limits exceed value width"); // R10
   end

   val_t ahr_q, amin_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ahr_q  <= AHR_OFF;
         amin_q <= '0;
      end else if (ed_fld == FLD_AHR) begin
         ahr_q  <= sat_step(ahr_q, ed_inc, ed_dec, '0, AHR_OFF);
      end else if (ed_fld == FLD_AMIN) begin
         amin_q <= sat_step(amin_q, ed_inc, ed_dec, '0, AMIN_HI);
      end
   end

   assign ahr_o  = ahr_q;
   assign amin_o = amin_q;

   AST_AHR_LIMIT: assert property (@(posedge clk) disable iff (rst)
      ahr_q <= AHR_OFF); // R10
   AST_AHR_SAT: assert property (@(posedge clk) disable iff (rst)
      (ed_inc && ed_fld == FLD_AHR && ahr_q == AHR_OFF) |=> ahr_q == AHR_OFF); // R6

endmodule

// File: rtl/cal_menu.sv
module cal_menu
   import cal_pkg::*;
#(
   parameter int TIMEOUT_S = 20
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     tick,
   input  logic     k_mode,
   input  logic     k_adj,
   input  logic     k_up,
   input  logic     k_dn,
   output menu_st_e st_o,
   output logic     ed_inc_o,
   output logic     ed_dec_o,
   output fld_e     ed_fld_o
);

   localparam int IW = $clog2(TIMEOUT_S + 1);
   localparam logic [IW-1:0] TO_LAST = IW'(TIMEOUT_S - 1);

   initial begin : elab_chk
      AST_TO_POSITIVE: assert (TIMEOUT_S >= 1)
         else $error("timeout must be at least one tick"); // R8
   end

   menu_st_e      st, nxt;
   logic [IW-1:0] idle;
   logic          editing, any_key, expire;

   assign editing = is_setting(st);
   assign any_key = k_mode | k_adj | k_up | k_dn;
   assign expire  = editing && !any_key && tick && (idle == TO_LAST);

   always_comb begin
      nxt = st;
      case (st)
         ST_TIME:  if (k_adj) nxt = ST_SMIN; else if (k_mode) nxt = ST_DATE;
         ST_DATE:  if (k_mode) nxt = ST_ALARM;
         ST_ALARM: if (k_adj) nxt = ST_AMIN; else if (k_mode) nxt = ST_TIME;
         ST_SMIN:  if (k_adj) nxt = ST_TIME; else if (k_mode) nxt = ST_SHR;
         ST_SHR:   if (k_adj) nxt = ST_TIME; else if (k_mode) nxt = ST_SDAY;
         ST_SDAY:  if (k_adj) nxt = ST_TIME; else if (k_mode) nxt = ST_SMON;
         ST_SMON:  if (k_adj) nxt = ST_TIME; else if (k_mode) nxt = ST_SYR;
         ST_SYR:   if (k_adj) nxt = ST_TIME; else if (k_mode) nxt = ST_SMIN;
         ST_AMIN:  if (k_adj) nxt = ST_ALARM; else if (k_mode) nxt = ST_AHR;
         ST_AHR:   if (k_adj) nxt = ST_ALARM; else if (k_mode) nxt = ST_AMIN;
         default:  nxt = ST_TIME;
      endcase
      if (expire) nxt = ST_TIME;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= ST_TIME;
         idle <= '0;
      end else begin
         st <= nxt;
         if (!editing || any_key) idle <= '0;
         else if (tick)           idle <= (idle == TO_LAST) ? '0 : idle + 1'b1;
      end
   end

   assign st_o     = st;
   assign ed_inc_o = editing && k_up && !k_adj && !k_mode;
   assign ed_dec_o = editing && k_dn && !k_adj && !k_mode && !k_up;
   assign ed_fld_o = state_field(st);

   AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (rst)
      (editing && tick && !any_key && idle == TO_LAST) |=> st == ST_TIME); // R8
   AST_CONFIRM: assert property (@(posedge clk) disable iff (rst)
      (st >= ST_SMIN && st <= ST_SYR && k_adj) |=> st == ST_TIME); // R7
   AST_ADJ_DATE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (st == ST_DATE && k_adj && !k_mode) |=> st == ST_DATE); // R3
   AST_TIME_ENTER: assert property (@(posedge clk) disable iff (rst)
      (st == ST_TIME && k_adj) |=> st == ST_SMIN); // R3

endmodule

// File: rtl/cal_view.sv
module cal_view
   import cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  menu_st_e   st,
   input  val_t       sec,
   input  val_t       min,
   input  val_t       hr,
   input  val_t       day,
   input  val_t       mon,
   input  val_t       yr,
   input  val_t       ahr,
   input  val_t       amin,
   output val_t       left_o,
   output val_t       mid_o,
   output val_t       right_o,
   output logic [2:0] blink_o
);

   always_comb begin
      case (st)
         ST_DATE, ST_SDAY, ST_SMON, ST_SYR: begin
            left_o = yr;  mid_o = mon;  right_o = day;
         end
         ST_ALARM, ST_AMIN, ST_AHR: begin
            left_o = ahr; mid_o = amin; right_o = '0;
         end
         default: begin
            left_o = hr;  mid_o = min;  right_o = sec;
         end
      endcase
   end

   always_comb begin
      case (st)
         ST_SMIN, ST_SMON, ST_AMIN: blink_o = BLK_MID;
         ST_SHR, ST_SYR, ST_AHR:    blink_o = BLK_LEFT;
         ST_SDAY:                   blink_o = BLK_RIGHT;
         default:                   blink_o = BLK_NONE;
      endcase
   end

   AST_BLINK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(blink_o)); // R4
   AST_BLINK_EDIT: assert property (@(posedge clk) disable iff (rst)
      is_setting(st) |-> $countones(blink_o) == 1); // R4

endmodule

// File: rtl/cal_clock_ctrl.sv
module cal_clock_ctrl
   import cal_pkg::*;
#(
   parameter int SEC_PER_MIN = 60,
   parameter int MIN_PER_HR  = 60,
   parameter int HR_PER_DAY  = 24,
   parameter int DAY_PER_MON = 30,
   parameter int MON_PER_YR  = 12,
   parameter int YR_SPAN     = 100,
   parameter int TIMEOUT_S   = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sec_tick_i,
   input  logic             key_mode_i,
   input  logic             key_adj_i,
   input  logic             key_up_i,
   input  logic             key_dn_i,
   output logic [VAL_W-1:0] disp_left_o,
   output logic [VAL_W-1:0] disp_mid_o,
   output logic [VAL_W-1:0] disp_right_o,
   output logic [2:0]       blink_sel_o,
   output logic [VAL_W-1:0] alarm_hr_o,
   output logic [VAL_W-1:0] alarm_min_o
);

   menu_st_e st;
   logic     ed_inc, ed_dec;
   fld_e     ed_fld;
   val_t     sec, min, hr, day, mon, yr, ahr, amin;

   cal_menu #(.TIMEOUT_S(TIMEOUT_S)) i_menu (
      .clk(clk), .rst(rst), .tick(sec_tick_i),
      .k_mode(key_mode_i), .k_adj(key_adj_i), .k_up(key_up_i), .k_dn(key_dn_i),
      .st_o(st), .ed_inc_o(ed_inc), .ed_dec_o(ed_dec), .ed_fld_o(ed_fld)
   );

   cal_timekeep #(
      .SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_HR(MIN_PER_HR), .HR_PER_DAY(HR_PER_DAY),
      .DAY_PER_MON(DAY_PER_MON), .MON_PER_YR(MON_PER_YR), .YR_SPAN(YR_SPAN)
   ) i_timekeep (
      .clk(clk), .rst(rst), .tick(sec_tick_i),
      .ed_inc(ed_inc), .ed_dec(ed_dec), .ed_fld(ed_fld),
      .sec_o(sec), .min_o(min), .hr_o(hr), .day_o(day), .mon_o(mon), .yr_o(yr)
   );

   cal_alarm_set #(.MIN_PER_HR(MIN_PER_HR), .HR_PER_DAY(HR_PER_DAY)) i_alarm (
      .clk(clk), .rst(rst), .ed_inc(ed_inc), .ed_dec(ed_dec), .ed_fld(ed_fld),
      .ahr_o(ahr), .amin_o(amin)
   );

   cal_view i_view (
      .clk(clk), .rst(rst), .st(st),
      .sec(sec), .min(min), .hr(hr), .day(day), .mon(mon), .yr(yr),
      .ahr(ahr), .amin(amin),
      .left_o(disp_left_o), .mid_o(disp_mid_o), .right_o(disp_right_o),
      .blink_o(blink_sel_o)
   );

   assign alarm_hr_o  = ahr;
   assign alarm_min_o = amin;

   AST_RESET_PAGE: assert property (@(posedge clk)
      $fell(rst) |-> (blink_sel_o == BLK_NONE && disp_mid_o == '0)); // R1

endmodule

// File: tb/test_cal_clock_ctrl.sv
`timescale 1ns/1ps
module test_cal_clock_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0, k_mode = 1'b0, k_adj = 1'b0, k_up = 1'b0, k_dn = 1'b0;
   logic [6:0] d_l, d_m, d_r, a_hr, a_min;
   logic [2:0] blink;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   cal_clock_ctrl i_cal_clock_ctrl (
      .clk(clk), .rst(rst), .sec_tick_i(tick),
      .key_mode_i(k_mode), .key_adj_i(k_adj), .key_up_i(k_up), .key_dn_i(k_dn),
      .disp_left_o(d_l), .disp_mid_o(d_m), .disp_right_o(d_r),
      .blink_sel_o(blink), .alarm_hr_o(a_hr), .alarm_min_o(a_min)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_disp(input string req, input int l, input int m, input int r);
      chk({req, " left"},  d_l, l);
      chk({req, " mid"},   d_m, m);
      chk({req, " right"}, d_r, r);
   endtask

   // each pulse lasts one cycle; sampling at the negedge after it sees the update
   task automatic p_mode(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) k_mode = 1'b1; @(negedge clk) k_mode = 1'b0;
      end
   endtask
   task automatic p_adj();
      @(negedge clk) k_adj = 1'b1; @(negedge clk) k_adj = 1'b0;
   endtask
   task automatic p_up(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) k_up = 1'b1; @(negedge clk) k_up = 1'b0;
      end
   endtask
   task automatic p_dn(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) k_dn = 1'b1; @(negedge clk) k_dn = 1'b0;
      end
   endtask
   task automatic p_tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1; @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      chk_disp("R1 reset time page", 0, 0, 0);
      chk("R1 reset blink", blink, 0);
      chk("R1 reset alarm hour", a_hr, 24);
      chk("R1 reset alarm minute", a_min, 0);
   endtask

   task automatic t_pages();
      p_mode(); chk_disp("R2 date page", 0, 1, 1);
      p_mode(); chk_disp("R2 alarm page", 24, 0, 0);
      p_mode(); chk_disp("R2 back to time", 0, 0, 0);
      chk("R2 blink off", blink, 0);
   endtask

   task automatic t_adj_on_date();
      p_mode(); p_adj();
      chk("R3 adjust on date ignored blink", blink, 0);
      chk_disp("R3 adjust on date ignored page", 0, 1, 1);
      p_mode(); chk("R3 still in page cycle", d_l, 24);
      p_mode(); chk_disp("R3 time again", 0, 0, 0);
   endtask

   task automatic t_edit();
      p_tick(5); chk("R9 seconds count", d_r, 5);
      p_adj(); chk("R3 enter minutes blink", blink, 3'b010);
      chk_disp("R3 time page in setting", 0, 0, 5);
      p_up(3); chk("R5 up minutes", d_m, 3);
      p_dn();  chk("R5 down minutes", d_m, 2);
      p_dn(5); chk("R6 minutes floor", d_m, 0);
      p_mode(); chk("R4 hours blink", blink, 3'b100);
      p_up(2); chk("R5 up hours", d_l, 2);
      p_mode(); chk("R4 day blink", blink, 3'b001);
      chk_disp("R4 day on date page", 0, 1, 1);
      p_up(); chk("R5 up day", d_r, 2);
      p_mode(); chk("R4 month blink", blink, 3'b010);
      p_mode(); chk("R4 year blink", blink, 3'b100);
      p_dn(); chk("R6 year floor", d_l, 0);
      p_up(); chk("R5 up year", d_l, 1);
      p_mode(); chk("R4 wrap to minutes blink", blink, 3'b010);
      chk_disp("R4 wrap to minutes page", 2, 0, 5);
      p_tick(3); chk("R9 counting in setting", d_r, 8);
      p_adj(); chk("R7 confirm blink", blink, 0);
      chk_disp("R7 edits kept", 2, 0, 8);
      p_mode(); chk_disp("R7 date edits kept", 1, 1, 2);
      p_mode(2);
   endtask

   task automatic t_timeout();
      p_adj();
      p_tick(19); chk("R8 still setting after 19", blink, 3'b010);
      p_up(); chk("R8 edit during idle wait", d_m, 1);
      p_tick(19); chk("R8 restarted count", blink, 3'b010);
      p_tick(1); chk("R8 timeout exit", blink, 0);
      chk_disp("R8 time page after timeout", 2, 1, 47);
   endtask

   task automatic t_rollover();
      p_adj();
      p_up(70); chk("R6 minutes ceiling", d_m, 59);
      p_mode(); p_up(30); chk("R6 hours ceiling", d_l, 23);
      p_mode(); p_up(40); chk("R6 day ceiling", d_r, 30);
      p_mode(); p_up(20); chk("R6 month ceiling", d_m, 12);
      p_mode(); p_up(120); chk("R6 year ceiling", d_l, 99);
      p_adj(); chk_disp("R7 confirmed max time", 23, 59, 47);
      p_tick(12); chk("R9 seconds to 59", d_r, 59);
      p_tick(1); chk_disp("R9 time rollover", 0, 0, 0);
      p_mode(); chk_disp("R9 date rollover", 0, 1, 1);
      p_mode(2);
   endtask

   task automatic t_alarm();
      p_mode(2); chk_disp("R10 alarm page", 24, 0, 0);
      p_adj(); chk("R10 alarm minute blink", blink, 3'b010);
      p_up(3); chk("R10 alarm minute up", d_m, 3);
      p_mode(); chk("R10 alarm hour blink", blink, 3'b100);
      p_dn(2); chk("R10 alarm hour down", d_l, 22);
      p_up(5); chk("R6 alarm hour ceiling", a_hr, 24);
      p_dn(); chk("R10 alarm hour 23", d_l, 23);
      p_adj(); chk("R10 alarm confirm blink", blink, 0);
      chk_disp("R10 alarm page after edit", 23, 3, 0);
      chk("R10 alarm hour port", a_hr, 23);
      chk("R10 alarm minute port", a_min, 3);
      p_mode(); chk_disp("R10 back to time", 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_pages();
      t_adj_on_date();
      t_edit();
      t_timeout();
      t_rollover();
      t_alarm();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule